// File: doc/BRIEF.md
# Dual Handshaked Parallel Port Controller

This block gives a processor two independent 8-bit parallel ports, A and B. Each port has a Ready output and a Strobe input for a handshake with the peripheral. Through a small register interface the processor picks one of four modes per port: output, input, bidirectional or bit control. Bidirectional mode exists only on port A. In that mode port A's handshake pair carries the outgoing byte and port B's pair carries the incoming one.

A finished handshake, or a bit-control match, marks the port's interrupt as pending. That way software does not have to poll the peripheral. The controller joins a priority chain through an enable-in and an enable-out line, so several of them can be cascaded. An acknowledge pulse takes the highest-priority request into service, and a return pulse releases the chain again.

The processor side has one write strobe and one read strobe, a port select and a select between the data and control registers. A control byte whose top two bits are 11 sets the mode from its low two bits. A control byte whose top two bits are 10 sets the interrupt enable from bit 0. After a bit-control mode byte, the next control byte is the direction mask and the one after it is the match pattern.

Top module: `pio_dual`

## Requirements
- R1: After reset both ports are in input mode (mode code 1) with Ready high, no pins driven, interrupts disabled, irq low and ie_out equal to ie_in. A control read returns {enable, 5'b0, mode}, registered one cycle after the read strobe.
- R2: A control byte with bits[7:6]=11 sets the port mode to bits[1:0] (0 output, 1 input, 2 bidirectional, 3 bit control). One with bits[7:6]=10 sets the interrupt enable to bit 0. Any other control byte, outside a mask/pattern sequence, changes nothing.
- R3: In output mode a data write latches the byte onto the port pins with every bit driven and raises Ready one cycle later. A rising Strobe while Ready is high drops Ready and marks the port pending.
- R4: In input mode Ready is high while the input latch is empty. A rising Strobe captures the pins, drops Ready and marks the port pending. A data read returns the captured byte and raises Ready again. A Strobe while the latch is full leaves the latch unchanged.
- R5: In bidirectional mode port A's Ready/Strobe handle the outgoing byte, and port B's Ready/Strobe capture port A's pins into A's input latch. Port A's pins are driven only while port A's Strobe is high.
- R6: Writing mode 2 to port B is ignored, and port B keeps its previous mode.
- R7: In bit-control mode the mask byte sets the direction (1 = input, so output enable = ~mask). A data read returns the input-bit pins merged with the output latch in the output bits.
- R8: In bit-control mode, once the pattern is loaded, the port goes pending each time the masked input bits change from not matching the pattern to matching it. A match that holds produces no further events.
- R9: irq is high exactly when ie_in is high and some port has both its pending flag and its enable set. A pending flag on a disabled port is kept, but it does not request.
- R10: ie_out is low whenever an enabled pending request or an in-service interrupt exists, and otherwise follows ie_in.
- R11: An acknowledge pulse (with ie_in high) clears the pending request of port A before that of port B and sets in-service. A return pulse clears in-service.
- R12: When a port's new handshake event falls in the same cycle as the acknowledge that clears that port, the port stays pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_we | input | 1 | Register write strobe |
| cpu_re | input | 1 | Register read strobe |
| cpu_port | input | 1 | Port select, 0 = A, 1 = B |
| cpu_ctrl | input | 1 | 1 = control register, 0 = data register |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Registered read data |
| pa_in | input | 8 | Port A pin input |
| pa_out | output | 8 | Port A pin output value |
| pa_oe | output | 8 | Port A per-bit output enable |
| pa_rdy | output | 1 | Port A Ready |
| pa_stb | input | 1 | Port A Strobe |
| pb_in | input | 8 | Port B pin input |
| pb_out | output | 8 | Port B pin output value |
| pb_oe | output | 8 | Port B per-bit output enable |
| pb_rdy | output | 1 | Port B Ready |
| pb_stb | input | 1 | Port B Strobe |
| ie_in | input | 1 | Chain enable from the higher-priority neighbour |
| ie_out | output | 1 | Chain enable to the lower-priority neighbour |
| irq | output | 1 | Interrupt request |
| int_ack | input | 1 | Interrupt acknowledge pulse |
| reti | input | 1 | Return-from-interrupt pulse |

## Verification
An acknowledge can clear a port's pending flag in the same cycle that port reports a new handshake event. The bench provokes this by raising port A's Strobe in the very cycle it pulses int_ack, just after a fresh data write has raised Ready. The collision is judged correct when irq is still high in the next cycle and a second acknowledge is needed to drop it. Sweeps over every data byte in output and input mode, and over every nibble in bit-control mode, surround that case.

// File: rtl/pio_pkg.sv
package pio_pkg;
  typedef enum logic [1:0] {
    PM_OUT = 2'd0,
    PM_IN  = 2'd1,
    PM_BI  = 2'd2,
    PM_BIT = 2'd3
  } pmode_t;

  typedef enum logic [1:0] {
    CF_IDLE = 2'd0,
    CF_MASK = 2'd1,
    CF_PAT  = 2'd2
  } cfg_t;

  localparam logic [1:0] OP_MODE = 2'b11;
  localparam logic [1:0] OP_IEN  = 2'b10;
endpackage

// File: rtl/pio_port.sv
module pio_port
  import pio_pkg::*;
#(
  parameter int DW        = 8,
  parameter bit HAS_BIDIR = 1'b1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ctrl_we,
  input  logic          data_we,
  input  logic          data_re,
  input  logic [DW-1:0] wdata,
  input  logic [DW-1:0] pin_in,
  output logic [DW-1:0] pin_out,
  output logic [DW-1:0] pin_oe,
  output logic          rdy,
  input  logic          stb,
  input  logic          aux_stb,
  output logic          aux_rdy,
  output logic [DW-1:0] rdata,
  output logic [1:0]    mode_o,
  output logic          int_en,
  output logic          evt
);
  pmode_t        mode;
  cfg_t          cfg_st;
  logic [DW-1:0] out_lat, in_lat, mask, pat;
  logic          out_full, in_full, armed, match_q, stb_q, aux_q;

  logic mode_set, cfg_wr, legal;
  logic stb_rise, aux_rise, out_ack, in_cap, rd_clear, match, bit_evt;

  assign legal    = HAS_BIDIR || (wdata[1:0] != 2'd2);
  assign mode_set = ctrl_we && (cfg_st == CF_IDLE) && (wdata[7:6] == OP_MODE) && legal;
  assign cfg_wr   = ctrl_we && (cfg_st != CF_IDLE);
  assign stb_rise = stb && !stb_q;
  assign aux_rise = aux_stb && !aux_q;
  assign out_ack  = stb_rise && out_full && (mode == PM_OUT || mode == PM_BI);
  assign in_cap   = !in_full && ((stb_rise && mode == PM_IN) || (aux_rise && mode == PM_BI));
  assign rd_clear = data_re && (mode == PM_IN || mode == PM_BI);
  assign match    = ((pin_in ^ pat) & mask) == '0;
  assign bit_evt  = armed && (mode == PM_BIT) && match && !match_q;
  assign evt      = out_ack || in_cap || bit_evt;

  // configuration: mode, enable, mask/pattern sequence
  always_ff @(posedge clk) begin
    if (rst) begin
      mode   <= PM_IN;
      cfg_st <= CF_IDLE;
      int_en <= 1'b0;
      mask   <= '0;
      pat    <= '0;
      armed  <= 1'b0;
    end else if (ctrl_we) begin
      case (cfg_st)
        CF_MASK: begin
          mask   <= wdata;
          cfg_st <= CF_PAT;
        end
        CF_PAT: begin
          pat    <= wdata;
          cfg_st <= CF_IDLE;
          armed  <= 1'b1;
        end
        default: begin
          if (mode_set) begin
            mode  <= pmode_t'(wdata[1:0]);
            armed <= 1'b0;
            if (wdata[1:0] == 2'd3) cfg_st <= CF_MASK;
          end else if (wdata[7:6] == OP_IEN) begin
            int_en <= wdata[0];
          end
        end
      endcase
    end
  end

  // data latches and handshake state
  always_ff @(posedge clk) begin
    if (rst) begin
      out_lat  <= '0;
      in_lat   <= '0;
      out_full <= 1'b0;
      in_full  <= 1'b0;
      stb_q    <= 1'b0;
      aux_q    <= 1'b0;
      match_q  <= 1'b1;
    end else begin
      stb_q <= stb;
      aux_q <= aux_stb;
      if (data_we) out_lat <= wdata;
      if (mode_set) begin
        out_full <= 1'b0;
        in_full  <= 1'b0;
      end else begin
        if (data_we && (mode == PM_OUT || mode == PM_BI)) out_full <= 1'b1;
        else if (out_ack)                                 out_full <= 1'b0;
        if (in_cap) begin
          in_lat  <= pin_in;
          in_full <= 1'b1;
        end else if (rd_clear) begin
          in_full <= 1'b0;
        end
      end
      if (cfg_wr || mode_set) match_q <= 1'b1;
      else                    match_q <= match;
    end
  end

  always_comb begin
    case (mode)
      PM_OUT:  pin_oe = '1;
      PM_IN:   pin_oe = '0;
      PM_BI:   pin_oe = stb ? '1 : '0;
      default: pin_oe = ~mask;
    endcase
    case (mode)
      PM_OUT:  rdata = out_lat;
      PM_BIT:  rdata = (pin_in & mask) | (out_lat & ~mask);
      default: rdata = in_lat;
    endcase
    case (mode)
      PM_OUT, PM_BI: rdy = out_full;
      PM_IN:         rdy = !in_full;
      default:       rdy = 1'b0;
    endcase
  end

  assign pin_out = out_lat;
  assign aux_rdy = (mode == PM_BI) && !in_full;
  assign mode_o  = mode;

  // R3: an accepted output strobe drops Ready next cycle
  p_rdy_drop_r3: assert property (@(posedge clk) disable iff (rst)
    (mode == PM_OUT && out_full && stb_rise && !data_we && !ctrl_we) |=> !rdy);
  // R4: input mode never drives the pins
  p_no_drive_r4: assert property (@(posedge clk) disable iff (rst)
    (mode == PM_IN) |-> (pin_oe == '0));
  // R4: a strobe on a full latch keeps its contents
  p_full_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (mode == PM_IN && in_full && stb_rise && !ctrl_we) |=> $stable(in_lat));
  // R7: in bit-control mode output enables are the inverted mask
  p_bit_dir_r7: assert property (@(posedge clk) disable iff (rst)
    (mode == PM_BIT && cfg_st == CF_IDLE) |-> (pin_oe == ~mask));

  generate
    if (!HAS_BIDIR) begin : g_nobi
      // R6: a port without the bidirectional variant never enters it
      p_no_bidir_r6: assert property (@(posedge clk) disable iff (rst)
        mode != PM_BI);
    end
  endgenerate
endmodule

// File: rtl/pio_intchain.sv
module pio_intchain #(
  parameter int NP = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [NP-1:0] evt,
  input  logic [NP-1:0] ien,
  input  logic          ack,
  input  logic          reti,
  input  logic          ie_in,
  output logic          irq,
  output logic          ie_out
);
  logic [NP-1:0] pend, req, grant, clr;
  logic          in_svc, take;

  assign req  = pend & ien;
  assign take = ack && ie_in && (|req);

  // lowest index wins
  always_comb begin
    grant = '0;
    for (int i = NP - 1; i >= 0; i--) begin
      if (req[i]) grant = NP'(1) << i;
    end
    clr = take ? grant : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend   <= '0;
      in_svc <= 1'b0;
    end else begin
      pend <= (pend & ~clr) | evt;
      if (take)      in_svc <= 1'b1;
      else if (reti) in_svc <= 1'b0;
    end
  end

  assign irq    = ie_in && (|req);
  assign ie_out = ie_in && !(|req) && !in_svc;

  // R10: a requesting device blocks the chain below it
  p_chain_block_r10: assert property (@(posedge clk) disable iff (rst)
    irq |-> !ie_out);
  // R11: acknowledge clears port A first
  p_ack_first_r11: assert property (@(posedge clk) disable iff (rst)
    (take && req[0] && !evt[0]) |=> !pend[0]);
  // R11: in service after acknowledge
  p_in_svc_r11: assert property (@(posedge clk) disable iff (rst)
    take |=> !ie_out);
  // R12: a new event is never lost to a concurrent clear
  p_evt_kept_r12: assert property (@(posedge clk) disable iff (rst)
    evt[0] |=> pend[0]);
endmodule

// File: rtl/pio_dual.sv
module pio_dual
  import pio_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cpu_we,
  input  logic          cpu_re,
  input  logic          cpu_port,
  input  logic          cpu_ctrl,
  input  logic [DW-1:0] cpu_wdata,
  output logic [DW-1:0] cpu_rdata,
  input  logic [DW-1:0] pa_in,
  output logic [DW-1:0] pa_out,
  output logic [DW-1:0] pa_oe,
  output logic          pa_rdy,
  input  logic          pa_stb,
  input  logic [DW-1:0] pb_in,
  output logic [DW-1:0] pb_out,
  output logic [DW-1:0] pb_oe,
  output logic          pb_rdy,
  input  logic          pb_stb,
  input  logic          ie_in,
  output logic          ie_out,
  output logic          irq,
  input  logic          int_ack,
  input  logic          reti
);
  localparam int NP = 2;

  logic [DW-1:0] a_rdata, b_rdata;
  logic [1:0]    a_mode, b_mode;
  logic          a_ien, b_ien, a_evt, b_evt;
  logic          a_aux_rdy, b_aux_rdy, b_rdy_own;
  logic          a_bidir, b_stb_eff, a_aux_stb;

  assign a_bidir   = (a_mode == 2'd2);
  assign b_stb_eff = a_bidir ? 1'b0 : pb_stb;
  assign a_aux_stb = a_bidir ? pb_stb : 1'b0;

  pio_port #(.DW(DW), .HAS_BIDIR(1'b1)) u_pa (
    .clk(clk), .rst(rst),
    .ctrl_we(cpu_we && cpu_ctrl && !cpu_port),
    .data_we(cpu_we && !cpu_ctrl && !cpu_port),
    .data_re(cpu_re && !cpu_ctrl && !cpu_port),
    .wdata(cpu_wdata), .pin_in(pa_in),
    .pin_out(pa_out), .pin_oe(pa_oe), .rdy(pa_rdy), .stb(pa_stb),
    .aux_stb(a_aux_stb), .aux_rdy(a_aux_rdy),
    .rdata(a_rdata), .mode_o(a_mode), .int_en(a_ien), .evt(a_evt)
  );

  pio_port #(.DW(DW), .HAS_BIDIR(1'b0)) u_pb (
    .clk(clk), .rst(rst),
    .ctrl_we(cpu_we && cpu_ctrl && cpu_port),
    .data_we(cpu_we && !cpu_ctrl && cpu_port),
    .data_re(cpu_re && !cpu_ctrl && cpu_port),
    .wdata(cpu_wdata), .pin_in(pb_in),
    .pin_out(pb_out), .pin_oe(pb_oe), .rdy(b_rdy_own), .stb(b_stb_eff),
    .aux_stb(1'b0), .aux_rdy(b_aux_rdy),
    .rdata(b_rdata), .mode_o(b_mode), .int_en(b_ien), .evt(b_evt)
  );

  // port B's own aux side never activates; it is folded in for completeness
  assign pb_rdy = a_bidir ? a_aux_rdy : (b_rdy_own | b_aux_rdy);

  pio_intchain #(.NP(NP)) u_chain (
    .clk(clk), .rst(rst),
    .evt({b_evt, a_evt}), .ien({b_ien, a_ien}),
    .ack(int_ack), .reti(reti), .ie_in(ie_in),
    .irq(irq), .ie_out(ie_out)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cpu_rdata <= '0;
    end else if (cpu_re) begin
      if (cpu_ctrl)
        cpu_rdata <= cpu_port ? {b_ien, {(DW-3){1'b0}}, b_mode}
                              : {a_ien, {(DW-3){1'b0}}, a_mode};
      else
        cpu_rdata <= cpu_port ? b_rdata : a_rdata;
    end
  end

  // R5: port A pins are undriven in bidirectional mode without its strobe
  p_bidir_oe_r5: assert property (@(posedge clk) disable iff (rst)
    (a_bidir && !pa_stb) |-> (pa_oe == '0));
endmodule

// File: tb/tb_pio_dual.sv
module tb_pio_dual;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cpu_we = 0, cpu_re = 0, cpu_port = 0, cpu_ctrl = 0;
  logic [7:0] cpu_wdata = 0, cpu_rdata;
  logic [7:0] pa_in = 0, pa_out, pa_oe, pb_in = 0, pb_out, pb_oe;
  logic       pa_rdy, pb_rdy, pa_stb = 0, pb_stb = 0;
  logic       ie_in = 1, ie_out, irq, int_ack = 0, reti = 0;
  int         vectors = 0, errors = 0;
  bit         done = 0;

  always #5 clk = ~clk;

  pio_dual dut (
    .clk(clk), .rst(rst), .cpu_we(cpu_we), .cpu_re(cpu_re), .cpu_port(cpu_port),
    .cpu_ctrl(cpu_ctrl), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .pa_in(pa_in), .pa_out(pa_out), .pa_oe(pa_oe), .pa_rdy(pa_rdy), .pa_stb(pa_stb),
    .pb_in(pb_in), .pb_out(pb_out), .pb_oe(pb_oe), .pb_rdy(pb_rdy), .pb_stb(pb_stb),
    .ie_in(ie_in), .ie_out(ie_out), .irq(irq), .int_ack(int_ack), .reti(reti)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic p, input logic c, input logic [7:0] d);
    cpu_we = 1; cpu_port = p; cpu_ctrl = c; cpu_wdata = d;
    tick();
    cpu_we = 0;
  endtask

  task automatic rd(input logic p, input logic c, output logic [7:0] d);
    cpu_re = 1; cpu_port = p; cpu_ctrl = c;
    tick();
    cpu_re = 0;
    d = cpu_rdata;
  endtask

  task automatic strobe_a();
    pa_stb = 1; tick(); pa_stb = 0; tick();
  endtask

  task automatic strobe_b();
    pb_stb = 1; tick(); pb_stb = 0; tick();
  endtask

  task automatic ack();
    int_ack = 1; tick(); int_ack = 0;
  endtask

  task automatic ret();
    reti = 1; tick(); reti = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      vectors++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] r;
    repeat (3) @(negedge clk);
    rst = 0;
    tick();
    // R1 reset state
    chk("R1 pa_oe", pa_oe, 8'h00);
    chk("R1 pb_oe", pb_oe, 8'h00);
    chk("R1 pa_rdy", pa_rdy, 1);
    chk("R1 pb_rdy", pb_rdy, 1);
    chk("R1 irq", irq, 0);
    chk("R1 ie_out", ie_out, 1);
    rd(0, 1, r); chk("R1 ctrl A", r, 8'h01);
    rd(1, 1, r); chk("R1 ctrl B", r, 8'h01);

    // R2 control decode
    wr(0, 1, 8'hC0); rd(0, 1, r); chk("R2 mode out", r, 8'h00);
    wr(0, 1, 8'h81); rd(0, 1, r); chk("R2 enable", r, 8'h80);
    wr(0, 1, 8'h3D); rd(0, 1, r); chk("R2 ignored byte", r, 8'h80);

    // R3 output sweep, with R9 R10 R11 on each event
    for (int v = 0; v < 256; v++) begin
      wr(0, 0, v[7:0]);
      chk("R3 pa_out", pa_out, v[7:0]);
      chk("R3 pa_oe", pa_oe, 8'hFF);
      chk("R3 rdy up", pa_rdy, 1);
      strobe_a();
      chk("R3 rdy down", pa_rdy, 0);
      chk("R9 irq", irq, 1);
      chk("R10 ie_out low", ie_out, 0);
      ack();
      chk("R11 irq cleared", irq, 0);
      chk("R11 in service", ie_out, 0);
      ret();
      chk("R11 released", ie_out, 1);
    end
    strobe_a();
    chk("R3 strobe without Ready", irq, 0);

    // R4 input sweep on B
    wr(1, 1, 8'h81);
    for (int v = 0; v < 256; v++) begin
      pb_in = v[7:0];
      chk("R4 rdy empty", pb_rdy, 1);
      chk("R4 no drive", pb_oe, 8'h00);
      strobe_b();
      chk("R4 rdy full", pb_rdy, 0);
      chk("R4 irq", irq, 1);
      pb_in = ~v[7:0];
      strobe_b();
      rd(1, 0, r);
      chk("R4 captured", r, v[7:0]);
      chk("R4 rdy again", pb_rdy, 1);
      ack(); ret();
      chk("R4 one event", irq, 0);
    end

    // R9 disabled pending is kept but silent
    wr(1, 1, 8'h80);
    strobe_b();
    chk("R9 disabled silent", irq, 0);
    chk("R10 chain open", ie_out, 1);
    wr(1, 1, 8'h81);
    chk("R9 pending kept", irq, 1);
    ack(); ret(); rd(1, 0, r);

    // R11 priority A over B
    wr(0, 0, 8'h11);
    strobe_a();
    strobe_b();
    ack();
    chk("R11 B still requests", irq, 1);
    wr(1, 1, 8'h80);
    chk("R11 A cleared first", irq, 0);
    chk("R11 held in service", ie_out, 0);
    wr(1, 1, 8'h81);
    chk("R11 B pending", irq, 1);
    ie_in = 0;
    #1;
    chk("R9 ie_in gates irq", irq, 0);
    chk("R10 ie_in gates ie_out", ie_out, 0);
    ie_in = 1;
    ack();
    chk("R11 B cleared", irq, 0);
    ret();
    chk("R11 chain free", ie_out, 1);
    rd(1, 0, r);

    // R12 ack and new event in the same cycle
    wr(0, 0, 8'h22);
    strobe_a();
    wr(0, 0, 8'h23);
    int_ack = 1; pa_stb = 1;
    tick();
    int_ack = 0; pa_stb = 0;
    tick();
    chk("R12 event kept", irq, 1);
    ack();
    chk("R12 second ack", irq, 0);
    ret();

    // R6 bidir refused on B
    wr(1, 1, 8'hC2); rd(1, 1, r); chk("R6 B mode kept", r, 8'h81);

    // R5 bidirectional on A; B in bit mode, all inputs, pattern 00
    wr(1, 1, 8'h80);
    wr(1, 1, 8'hC3); wr(1, 1, 8'hFF); wr(1, 1, 8'h00);
    pb_in = 8'h00;
    wr(0, 1, 8'hC2);
    chk("R5 no drive idle", pa_oe, 8'h00);
    chk("R5 A rdy empty", pa_rdy, 0);
    chk("R5 B rdy input empty", pb_rdy, 1);
    wr(0, 0, 8'h5A);
    chk("R5 A rdy", pa_rdy, 1);
    chk("R5 still undriven", pa_oe, 8'h00);
    pa_stb = 1; #1;
    chk("R5 drive on strobe", pa_oe, 8'hFF);
    chk("R5 value", pa_out, 8'h5A);
    tick();
    chk("R5 A rdy drop", pa_rdy, 0);
    pa_stb = 0; #1;
    chk("R5 release", pa_oe, 8'h00);
    tick();
    ack(); ret();
    pa_in = 8'hC3;
    strobe_b();
    chk("R5 B rdy full", pb_rdy, 0);
    chk("R5 input event", irq, 1);
    rd(0, 0, r);
    chk("R5 captured", r, 8'hC3);
    chk("R5 B rdy again", pb_rdy, 1);
    ack(); ret();

    // R7 R8 bit control on B: mask 0F, pattern 05
    wr(0, 1, 8'hC1);
    pb_in = 8'h00;
    wr(1, 1, 8'hC3); wr(1, 1, 8'h0F); wr(1, 1, 8'h05);
    chk("R7 direction", pb_oe, 8'hF0);
    wr(1, 0, 8'hAA);
    chk("R7 out latch", pb_out, 8'hAA);
    wr(1, 1, 8'h81);
    for (int n = 0; n < 16; n++) begin
      pb_in = {4'h3, n[3:0]};
      tick();
      chk("R8 match event", irq, (n == 5) ? 1 : 0);
      rd(1, 0, r);
      chk("R7 merged read", r, {4'hA, n[3:0]});
      if (n == 5) begin
        ack(); ret();
        pb_in = 8'hF5;
        tick(); tick();
        chk("R8 held match silent", irq, 0);
      end
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule